// File: doc/BRIEF.md
# Zone Access Permission Unit

This block decides whether a virtual-mode memory access may go ahead. The page's translation entry supplies three bits: valid, write-enable and execute-enable. The block combines them with a per-zone override code, the current privilege mode and the class of access. The result is an allow signal. When the access is refused, the block also raises either an instruction-side fault or a data-side fault.

The override codes sit in a 32-bit zone register. The register holds sixteen 2-bit fields, and the translation entry's 4-bit zone index picks one of them. Software reads and writes the register through a special-register move port at address 944 (0x3B0). The port answers only in privileged mode. A user-mode attempt is refused and flagged.

Cache-maintenance operations are judged as data accesses. Two of them follow rules of their own: block-invalidate and block-zero. The allow decision is purely combinational. A register write takes effect at the next clock edge.

Top module: `zone_guard`

## Requirements
- R1: While reset is low, and after it is released, the zone register holds all zeros. A privileged read returns 0 until the register is first written.
- R2: A privileged move-to at address 944 (0x3B0) loads `spr_wdata_i` at the next clock edge. A privileged move-from at that address returns the register on `spr_rdata_o` in the same cycle. Any other address leaves `spr_hit_o` low, reads return 0, and the register does not change.
- R3: A move at address 944 made in user mode (`user_mode_i`=1) raises `spr_priv_fault_o` in the same cycle and returns 0 on `spr_rdata_o`. The register keeps its contents.
- R4: The field for zone z occupies register bits [31-2z : 30-2z], with bit 31-2z as the code's upper bit. Zone 0 is therefore bits 31:30 and zone 15 is bits 1:0.
- R5: In user mode, zone code 00 denies every access class except block-invalidate.
- R6: In user mode, codes 01 and 10 apply the entry bits unchanged. A load needs valid. A store needs valid and write. A fetch needs valid and execute.
- R7: In user mode, code 11 treats the page as writable and executable. Valid is still required.
- R8: In privileged mode, codes 00 and 01 apply the entry bits unchanged. Codes 10 and 11 treat the page as writable and executable, and valid is still required.
- R9: Access classes are encoded on `acc_kind_i` as 0 load, 1 store, 2 fetch, 3 cache-touch, 4 cache-write, 5 block-invalidate, 6 block-zero and 7 reserved. A cache-touch is judged as a load. A cache-write (flush or store-like maintenance) is judged as a store, with zone overrides applied. The reserved class is always denied.
- R10: A block-invalidate is allowed exactly when the entry's valid and write bits are both 1, whatever the zone code or mode.
- R11: A block-zero needs the entry's valid bit and its unforced write bit. In user mode it is also denied by zone code 00.
- R12: With `acc_req_i` high, exactly one of `acc_allow_o`, `acc_ifault_o` and `acc_dfault_o` is 1. A denied fetch raises the instruction fault. Any other denied class raises the data fault. With `acc_req_i` low, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode_i | input | 1 | 1 = user mode, 0 = privileged mode |
| spr_req_i | input | 1 | Special-register move request |
| spr_wr_i | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| spr_addr_i | input | 10 | Special-register address |
| spr_wdata_i | input | 32 | Write data |
| spr_rdata_o | output | 32 | Read data, 0 unless a privileged read hits |
| spr_hit_o | output | 1 | Request addresses the zone register |
| spr_priv_fault_o | output | 1 | User-mode move was refused |
| acc_req_i | input | 1 | Access check request |
| acc_kind_i | input | 3 | Access class (see R9) |
| zone_i | input | 4 | Zone index from translation entry |
| tlb_valid_i | input | 1 | Entry valid bit |
| tlb_wr_i | input | 1 | Entry write-enable bit |
| tlb_ex_i | input | 1 | Entry execute-enable bit |
| acc_allow_o | output | 1 | Access permitted |
| acc_ifault_o | output | 1 | Instruction-side fault |
| acc_dfault_o | output | 1 | Data-storage fault |

## Verification
The allow, fault, hit, privilege-fault and read-data outputs depend on the current inputs and the current register value. They are due in the same cycle as the stimulus. A register write changes what later reads and checks see, starting from the cycle after the clock edge that takes it. The bench drives inputs at the falling edge and compares all outputs 2 ns later against a behavioural model. The model updates its copy of the register only after the next rising edge, so every check made before that edge still sees the old contents.

// File: rtl/zg_pkg.sv
package zg_pkg;
    localparam int ZG_ZONES   = 16;
    localparam int ZG_CODE_W  = 2;
    localparam int ZG_ADDR_W  = 10;
    localparam int ZG_ADDR    = 944;

    typedef enum logic [2:0] {
        ACC_LOAD      = 3'd0,
        ACC_STORE     = 3'd1,
        ACC_FETCH     = 3'd2,
        ACC_CC_TOUCH  = 3'd3,
        ACC_CC_WRITE  = 3'd4,
        ACC_BLK_INVAL = 3'd5,
        ACC_BLK_ZERO  = 3'd6,
        ACC_RSVD      = 3'd7
    } acc_kind_e;

    typedef enum logic [1:0] {
        ZC_LOCK  = 2'b00,
        ZC_PASSA = 2'b01,
        ZC_PASSB = 2'b10,
        ZC_OPEN  = 2'b11
    } zone_code_e;
endpackage

// File: rtl/zg_spr_port.sv
module zg_spr_port #(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 10,
    parameter int ADDR   = 944
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_mode_i,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              hit_o,
    output logic              priv_fault_o,
    output logic [REG_W-1:0]  zones_o
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(ADDR);

    typedef struct packed {
        logic [REG_W-1:0] zones;
    } spr_state_t;

    spr_state_t st_d, st_q;
    logic       granted;

    always_comb begin
        st_d         = st_q;
        hit_o        = req_i && (addr_i == MATCH);
        granted      = hit_o && !user_mode_i;
        priv_fault_o = hit_o && user_mode_i;
        rdata_o      = '0;
        if (granted && wr_i) begin
            st_d.zones = wdata_i;
        end
        if (granted && !wr_i) begin
            rdata_o = st_q.zones;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign zones_o = st_q.zones;
endmodule

// File: rtl/zg_zone_select.sv
module zg_zone_select #(
    parameter int ZONES  = 16,
    parameter int CODE_W = 2,
    localparam int REG_W = ZONES * CODE_W,
    localparam int IDX_W = $clog2(ZONES)
) (
    input  logic [REG_W-1:0]  zones_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] codes [ZONES];

    // Zone 0 sits in the most significant field.
    for (genvar g = 0; g < ZONES; g++) begin : g_field
        assign codes[g] = zones_i[REG_W-1-CODE_W*g -: CODE_W];
    end

    assign code_o = codes[idx_i];
endmodule

// File: rtl/zg_perm_eval.sv
module zg_perm_eval
    import zg_pkg::*;
(
    input  logic       req_i,
    input  logic [2:0] kind_i,
    input  logic       user_mode_i,
    input  logic [1:0] code_i,
    input  logic       v_i,
    input  logic       w_i,
    input  logic       x_i,
    output logic       allow_o,
    output logic       ifault_o,
    output logic       dfault_o
);
    acc_kind_e  kind;
    zone_code_e code;
    logic       locked, force_wx, eff_w, eff_x, ok, deny;

    always_comb begin
        kind     = acc_kind_e'(kind_i);
        code     = zone_code_e'(code_i);
        locked   = user_mode_i && (code == ZC_LOCK);
        force_wx = user_mode_i ? (code == ZC_OPEN)
                               : (code == ZC_PASSB || code == ZC_OPEN);
        eff_w    = w_i || force_wx;
        eff_x    = x_i || force_wx;
        unique case (kind)
            ACC_LOAD, ACC_CC_TOUCH:  ok = v_i && !locked;
            ACC_STORE, ACC_CC_WRITE: ok = v_i && eff_w && !locked;
            ACC_FETCH:               ok = v_i && eff_x && !locked;
            ACC_BLK_INVAL:           ok = v_i && w_i;
            ACC_BLK_ZERO:            ok = v_i && w_i && !locked;
            default:                 ok = 1'b0;
        endcase
        deny     = req_i && !ok;
        allow_o  = req_i && ok;
        ifault_o = deny && (kind == ACC_FETCH);
        dfault_o = deny && (kind != ACC_FETCH);
    end
endmodule

// File: rtl/zone_guard.sv
module zone_guard
    import zg_pkg::*;
#(
    parameter int ZONES      = ZG_ZONES,
    parameter int SPR_ADDR_W = ZG_ADDR_W,
    parameter int SPR_ADDR   = ZG_ADDR,
    localparam int REG_W     = ZONES * ZG_CODE_W,
    localparam int IDX_W     = $clog2(ZONES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  user_mode_i,
    input  logic                  spr_req_i,
    input  logic                  spr_wr_i,
    input  logic [SPR_ADDR_W-1:0] spr_addr_i,
    input  logic [REG_W-1:0]      spr_wdata_i,
    output logic [REG_W-1:0]      spr_rdata_o,
    output logic                  spr_hit_o,
    output logic                  spr_priv_fault_o,
    input  logic                  acc_req_i,
    input  logic [2:0]            acc_kind_i,
    input  logic [IDX_W-1:0]      zone_i,
    input  logic                  tlb_valid_i,
    input  logic                  tlb_wr_i,
    input  logic                  tlb_ex_i,
    output logic                  acc_allow_o,
    output logic                  acc_ifault_o,
    output logic                  acc_dfault_o
);
    logic [REG_W-1:0]     zones_q;
    logic [ZG_CODE_W-1:0] code;

    zg_spr_port #(
        .REG_W (REG_W),
        .ADDR_W(SPR_ADDR_W),
        .ADDR  (SPR_ADDR)
    ) u_spr (
        .clk         (clk),
        .rst_n       (rst_n),
        .user_mode_i (user_mode_i),
        .req_i       (spr_req_i),
        .wr_i        (spr_wr_i),
        .addr_i      (spr_addr_i),
        .wdata_i     (spr_wdata_i),
        .rdata_o     (spr_rdata_o),
        .hit_o       (spr_hit_o),
        .priv_fault_o(spr_priv_fault_o),
        .zones_o     (zones_q)
    );

    zg_zone_select #(
        .ZONES (ZONES),
        .CODE_W(ZG_CODE_W)
    ) u_sel (
        .zones_i(zones_q),
        .idx_i  (zone_i),
        .code_o (code)
    );

    zg_perm_eval u_eval (
        .req_i      (acc_req_i),
        .kind_i     (acc_kind_i),
        .user_mode_i(user_mode_i),
        .code_i     (code),
        .v_i        (tlb_valid_i),
        .w_i        (tlb_wr_i),
        .x_i        (tlb_ex_i),
        .allow_o    (acc_allow_o),
        .ifault_o   (acc_ifault_o),
        .dfault_o   (acc_dfault_o)
    );
endmodule

// File: rtl/zone_guard_chk.sv
module zone_guard_chk #(
    parameter int REG_W  = 32,
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 10,
    parameter int ADDR   = 944
) (
    input logic              clk,
    input logic              rst_n,
    input logic              user_mode_i,
    input logic              spr_req_i,
    input logic              spr_wr_i,
    input logic [ADDR_W-1:0] spr_addr_i,
    input logic [REG_W-1:0]  spr_wdata_i,
    input logic [REG_W-1:0]  spr_rdata_o,
    input logic              acc_req_i,
    input logic [2:0]        acc_kind_i,
    input logic [IDX_W-1:0]  zone_i,
    input logic              tlb_valid_i,
    input logic              tlb_wr_i,
    input logic              acc_allow_o,
    input logic              acc_ifault_o,
    input logic              acc_dfault_o,
    input logic [REG_W-1:0]  zones_q
);
    logic       at_reg;
    logic [1:0] sel_code;

    assign at_reg   = spr_req_i && (spr_addr_i == ADDR_W'(ADDR));
    assign sel_code = zones_q[REG_W-1-2*zone_i -: 2];

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> zones_q == '0);

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (at_reg && !user_mode_i && spr_wr_i) |=> zones_q == $past(spr_wdata_i));

    p_user_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (at_reg && user_mode_i) |=> $stable(zones_q));

    p_user_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (at_reg && user_mode_i) |-> spr_rdata_o == '0);

    p_lock_denies_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_i && user_mode_i && sel_code == 2'b00 && acc_kind_i != 3'd5)
        |-> !acc_allow_o);

    p_inval_zone_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_i && acc_kind_i == 3'd5) |-> acc_allow_o == (tlb_valid_i && tlb_wr_i));

    p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({acc_allow_o, acc_ifault_o, acc_dfault_o}) == (acc_req_i ? 1 : 0));

    p_fetch_side_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_i && acc_kind_i != 3'd2) |-> !acc_ifault_o);
endmodule

bind zone_guard zone_guard_chk #(
    .REG_W (REG_W),
    .IDX_W (IDX_W),
    .ADDR_W(SPR_ADDR_W),
    .ADDR  (SPR_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .user_mode_i(user_mode_i),
    .spr_req_i  (spr_req_i),
    .spr_wr_i   (spr_wr_i),
    .spr_addr_i (spr_addr_i),
    .spr_wdata_i(spr_wdata_i),
    .spr_rdata_o(spr_rdata_o),
    .acc_req_i  (acc_req_i),
    .acc_kind_i (acc_kind_i),
    .zone_i     (zone_i),
    .tlb_valid_i(tlb_valid_i),
    .tlb_wr_i   (tlb_wr_i),
    .acc_allow_o(acc_allow_o),
    .acc_ifault_o(acc_ifault_o),
    .acc_dfault_o(acc_dfault_o),
    .zones_q    (zones_q)
);

// File: tb/tb_zone_guard.sv
module tb_zone_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        user_mode_i = 1'b0;
    logic        spr_req_i = 1'b0;
    logic        spr_wr_i = 1'b0;
    logic [9:0]  spr_addr_i = '0;
    logic [31:0] spr_wdata_i = '0;
    logic [31:0] spr_rdata_o;
    logic        spr_hit_o, spr_priv_fault_o;
    logic        acc_req_i = 1'b0;
    logic [2:0]  acc_kind_i = '0;
    logic [3:0]  zone_i = '0;
    logic        tlb_valid_i = 1'b0, tlb_wr_i = 1'b0, tlb_ex_i = 1'b0;
    logic        acc_allow_o, acc_ifault_o, acc_dfault_o;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] model_reg = '0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    zone_guard dut (.*);

    function automatic logic [1:0] zcode(input logic [31:0] r, input int z);
        logic [1:0] c;
        c[1] = r[31 - 2*z];
        c[0] = r[30 - 2*z];
        return c;
    endfunction

    function automatic bit ref_allow(input int kind, input bit user, input logic [1:0] c,
                                     input bit v, input bit w, input bit x);
        bit locked, open;
        locked = user && (c == 2'd0);
        if (user) open = (c == 2'd3);
        else      open = (c >= 2'd2);
        if (kind == 5) return v && w;
        if (kind == 6) return v && w && !locked;
        if (kind == 7 || locked || !v) return 0;
        if (kind == 0 || kind == 3) return 1;
        if (kind == 2) return x || open;
        return w || open;
    endfunction

    function automatic string acc_tag(input int kind, input bit user, input logic [1:0] c);
        if (kind == 5) return "R10";
        if (kind == 6) return "R11";
        if (kind >= 3) return "R9";
        if (!user) return "R8";
        if (c == 2'd0) return "R5";
        if (c == 2'd3) return "R7";
        return "R6";
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare 2 ns after the inputs settle, then commit model writes after the edge.
    task automatic step(input string spr_tag);
        bit          hit, ok;
        logic [1:0]  c;
        logic [31:0] exp_rd;
        string       t;
        #2;
        hit    = spr_req_i && (spr_addr_i == 10'd944);
        exp_rd = (hit && !user_mode_i && !spr_wr_i) ? model_reg : 32'h0;
        check(spr_tag, "rdata", spr_rdata_o, exp_rd);
        check(spr_tag, "hit/pfault", {30'd0, spr_hit_o, spr_priv_fault_o},
              {30'd0, hit, hit && user_mode_i});
        c  = zcode(model_reg, int'(zone_i));
        ok = ref_allow(int'(acc_kind_i), user_mode_i, c, tlb_valid_i, tlb_wr_i, tlb_ex_i);
        t  = acc_tag(int'(acc_kind_i), user_mode_i, c);
        check(acc_req_i ? t : "R12", "allow", {31'd0, acc_allow_o}, {31'd0, acc_req_i && ok});
        check("R12", "ifault/dfault", {30'd0, acc_ifault_o, acc_dfault_o},
              {30'd0, acc_req_i && !ok && acc_kind_i == 3'd2,
                      acc_req_i && !ok && acc_kind_i != 3'd2});
        @(posedge clk);
        if (rst_n && hit && !user_mode_i && spr_wr_i) model_reg = spr_wdata_i;
        if (!rst_n) model_reg = '0;
    endtask

    task automatic spr_op(input bit user, input bit wr, input logic [9:0] a,
                          input logic [31:0] d, input string tag);
        @(negedge clk);
        acc_req_i = 0;
        user_mode_i = user; spr_req_i = 1; spr_wr_i = wr; spr_addr_i = a; spr_wdata_i = d;
        step(tag);
        @(negedge clk);
        spr_req_i = 0;
    endtask

    task automatic access(input bit user, input int kind, input int z, input bit v,
                          input bit w, input bit x);
        @(negedge clk);
        spr_req_i = 0;
        user_mode_i = user; acc_req_i = 1; acc_kind_i = 3'(kind); zone_i = 4'(z);
        tlb_valid_i = v; tlb_wr_i = w; tlb_ex_i = x;
        step("R12");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: register clear during and after reset
        spr_op(0, 0, 10'd944, '0, "R1");
        spr_op(0, 1, 10'd944, 32'hFFFF_FFFF, "R1");
        @(negedge clk); rst_n = 1;
        spr_op(0, 0, 10'd944, '0, "R1");
        // R2: write, read back, other address ignored
        spr_op(0, 1, 10'd944, 32'hA5C3_0F96, "R2");
        spr_op(0, 0, 10'd944, '0, "R2");
        spr_op(0, 1, 10'd945, 32'h1234_5678, "R2");
        spr_op(0, 0, 10'd945, '0, "R2");
        spr_op(0, 0, 10'd944, '0, "R2");
        // R3: user moves refused
        spr_op(1, 1, 10'd944, 32'hFFFF_FFFF, "R3");
        spr_op(1, 0, 10'd944, '0, "R3");
        spr_op(0, 0, 10'd944, '0, "R3");
        // R4: field placement, zone 0 open, zone 15 open, others locked
        spr_op(0, 1, 10'd944, 32'hC000_0003, "R4");
        access(1, 1, 0, 1, 0, 0);
        access(1, 1, 1, 1, 0, 0);
        access(1, 2, 15, 1, 0, 0);
        access(1, 2, 14, 1, 1, 1);
        // R5-R11: zone z carries code z mod 4
        spr_op(0, 1, 10'd944, 32'h1B1B_1B1B, "R4");
        for (int u = 0; u < 2; u++)
            for (int k = 0; k < 8; k++)
                for (int z = 0; z < 8; z++)
                    for (int b = 0; b < 8; b++)
                        access(u[0], k, z, b[2], b[1], b[0]);
        // R12: idle request gives no outcome
        @(negedge clk); acc_req_i = 0; step("R12");
        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            user_mode_i = $urandom_range(0, 3) == 0;
            spr_req_i   = $urandom_range(0, 3) == 0;
            spr_wr_i    = $urandom_range(0, 1) == 1;
            spr_addr_i  = ($urandom_range(0, 3) != 0) ? 10'd944 : 10'($urandom);
            spr_wdata_i = $urandom;
            acc_req_i   = $urandom_range(0, 7) != 0;
            acc_kind_i  = 3'($urandom);
            zone_i      = 4'($urandom);
            {tlb_valid_i, tlb_wr_i, tlb_ex_i} = 3'($urandom);
            step(spr_req_i && user_mode_i ? "R3" : "R2");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule